// File: doc/BRIEF.md
# SD Command Response Status Capture

This block takes the status field of a command response from an SD or SDIO command line, one bit at a time, and places it into four 32-bit response words that a host bus can read. A start strobe arms a capture. A response-type input, sampled at that strobe, selects one of two modes. In the short mode the status field is 32 bits wide. In the long mode it is 127 bits wide, holding status bits 127 down to 1.

Bits are taken only on cycles where the card-clock enable is high, and they arrive most significant bit first. When the final bit has been taken, the four words are updated together and a one-cycle done pulse is raised. The words cannot be written from the host side. A read address picks one word, and the registered read data follows one cycle later. Start-bit detection, command-index checking, CRC checking and the command sequencing stay outside this block.

Top module: `sd_rsp_deser`

## Requirements
- R1: After reset, all four response words read as zero and done_o is low.
- R2: A bit on bit_i is taken only in a cycle where bit_en_i is high during a capture. Cycles with bit_en_i low change nothing, whatever bit_i holds.
- R3: Short mode (long_i=0 at start): the 32 received bits form status[31:0], with the first bit received being status[31]. Word 0 (rd_addr_i=0) reads status[31:0], and words 1 to 3 read zero.
- R4: Long mode (long_i=1 at start): the 127 received bits form status[127:1], with the first bit received being status[127]. Word 0 reads status[127:96], word 1 reads [95:64], word 2 reads [63:32], and word 3 bits 31:1 read status[31:1].
- R5: Bit 0 of word 3 always reads 0.
- R6: done_o is high for exactly one cycle. It rises in the cycle after the clock edge that takes the final bit (bit 32 or bit 127). Enabled bits that arrive after completion and before the next start are ignored.
- R7: start_i clears all four words and the bit count, and restarts the capture even if one is already in progress. When start_i and bit_en_i are high in the same cycle, the start wins and the bit is dropped.
- R8: rd_data_o shows the word selected by rd_addr_i one cycle after the address is presented. The words change only on a start or on the completion of a capture.
- R9: The mode is latched at start_i. A change of long_i during a capture has no effect on that capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe that arms a capture |
| long_i | input | 1 | Response type: 1 for long (127 bits), 0 for short (32 bits) |
| bit_en_i | input | 1 | Card-clock enable; a bit is taken when this is high |
| bit_i | input | 1 | Serial status bit from the command line |
| done_o | output | 1 | One-cycle pulse when a capture has completed |
| rd_addr_i | input | 2 | Selects a response word, 0 to 3 |
| rd_data_o | output | 32 | Registered read data of the selected word |

## Verification
A start strobe can fall in the same cycle as the enabled final bit of a capture. In that cycle, restart and completion compete. The bench provokes this by sending 31 short-mode bits and then driving start_i and bit_en_i high together. It then checks that no done pulse follows, that word 0 reads zero, and that a fresh 32-bit capture starting from count zero completes normally. A second collision, between a read and the completion edge, is judged by reading just after done_o and expecting the new word.

// File: rtl/sdrc_pkg.sv
package sdrc_pkg;
  parameter int WORD_W     = 32;
  parameter int NWORDS     = 4;
  parameter int SHORT_BITS = 32;
  localparam int LONG_BITS = NWORDS * WORD_W - 1;
  localparam int CNT_W     = $clog2(LONG_BITS + 1);
  localparam int AW        = $clog2(NWORDS);
endpackage

// File: rtl/sdrc_bitcnt.sv
module sdrc_bitcnt #(
  parameter int LONG_BITS  = 127,
  parameter int SHORT_BITS = 32,
  parameter int CNT_W      = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic long_i,
  input  logic bit_en_i,
  output logic busy_o,
  output logic long_o,
  output logic adv_o,
  output logic last_o
);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_BITS - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_BITS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             long_q;
  logic [CNT_W-1:0] lim;

  always_comb begin
    lim    = long_q ? LONG_LAST : SHORT_LAST;
    adv_o  = busy_q && bit_en_i && !start_i;
    last_o = adv_o && (cnt_q == lim);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      long_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
      long_q <= long_i;
    end else if (adv_o) begin
      if (last_o) begin
        cnt_q  <= '0;
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign long_o = long_q;
endmodule

// File: rtl/sdrc_shift.sv
module sdrc_shift #(
  parameter int SH_W = 127
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            adv_i,
  input  logic            bit_i,
  output logic [SH_W-1:0] sh_nx_o
);
  logic [SH_W-1:0] sh_q;

  assign sh_nx_o = {sh_q[SH_W-2:0], bit_i};

  always_ff @(posedge clk) begin
    if (rst || start_i) sh_q <= '0;
    else if (adv_i)     sh_q <= sh_nx_o;
  end
endmodule

// File: rtl/sdrc_regfile.sv
module sdrc_regfile #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 4,
  parameter int AW     = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start_i,
  input  logic                          commit_i,
  input  logic                          long_i,
  input  logic [NWORDS*WORD_W-2:0]      sh_nx_i,
  input  logic [AW-1:0]                 rd_addr_i,
  output logic [WORD_W-1:0]             rd_data_o,
  output logic [NWORDS-1:0][WORD_W-1:0] rsp_o
);
  localparam int FULL_W = NWORDS * WORD_W;

  logic [FULL_W-1:0]              full;
  logic [NWORDS-1:0][WORD_W-1:0]  long_word;
  logic [NWORDS-1:0][WORD_W-1:0]  short_word;
  logic [NWORDS-1:0][WORD_W-1:0]  rsp_q;
  logic [WORD_W-1:0]              rd_q;

  // Long layout: received bits fill from the top, a constant zero pads the bottom.
  assign full = {sh_nx_i, 1'b0};

  for (genvar g = 0; g < NWORDS; g++) begin : g_place
    assign long_word[g] = full[FULL_W-1-g*WORD_W -: WORD_W];
    if (g == 0) begin : g_first
      assign short_word[g] = sh_nx_i[WORD_W-1:0];
    end else begin : g_rest
      assign short_word[g] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      rsp_q <= '0;
    end else if (commit_i) begin
      for (int i = 0; i < NWORDS; i++)
        rsp_q[i] <= long_i ? long_word[i] : short_word[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rsp_q[rd_addr_i];
  end

  assign rd_data_o = rd_q;
  assign rsp_o     = rsp_q;
endmodule

// File: rtl/sd_rsp_deser.sv
module sd_rsp_deser
  import sdrc_pkg::*;
#(
  parameter int P_WORD_W     = WORD_W,
  parameter int P_NWORDS     = NWORDS,
  parameter int P_SHORT_BITS = SHORT_BITS
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start_i,
  input  logic                           long_i,
  input  logic                           bit_en_i,
  input  logic                           bit_i,
  output logic                           done_o,
  input  logic [$clog2(P_NWORDS)-1:0]    rd_addr_i,
  output logic [P_WORD_W-1:0]            rd_data_o
);
  localparam int L_LONG = P_NWORDS * P_WORD_W - 1;
  localparam int L_CNTW = $clog2(L_LONG + 1);
  localparam int L_AW   = $clog2(P_NWORDS);

  logic                              busy;
  logic                              long_q;
  logic                              adv;
  logic                              last;
  logic                              done_q;
  logic [L_LONG-1:0]                 sh_nx;
  logic [P_NWORDS-1:0][P_WORD_W-1:0] rsp_w;

  sdrc_bitcnt #(
    .LONG_BITS (L_LONG),
    .SHORT_BITS(P_SHORT_BITS),
    .CNT_W     (L_CNTW)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .long_i  (long_i),
    .bit_en_i(bit_en_i),
    .busy_o  (busy),
    .long_o  (long_q),
    .adv_o   (adv),
    .last_o  (last)
  );

  sdrc_shift #(.SH_W(L_LONG)) u_sh (
    .clk    (clk),
    .rst    (rst),
    .start_i(start_i),
    .adv_i  (adv),
    .bit_i  (bit_i),
    .sh_nx_o(sh_nx)
  );

  sdrc_regfile #(
    .WORD_W(P_WORD_W),
    .NWORDS(P_NWORDS),
    .AW    (L_AW)
  ) u_rf (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .commit_i (last),
    .long_i   (long_q),
    .sh_nx_i  (sh_nx),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o),
    .rsp_o    (rsp_w)
  );

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else     done_q <= last;
  end

  assign done_o = done_q;
endmodule

// File: rtl/sdrc_chk.sv
module sdrc_chk #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 4
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           start_i,
  input logic                           bit_en_i,
  input logic                           done_o,
  input logic [$clog2(NWORDS)-1:0]      rd_addr_i,
  input logic [WORD_W-1:0]              rd_data_o,
  input logic                           busy,
  input logic                           long_q,
  input logic [NWORDS-1:0][WORD_W-1:0]  rsp
);
  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_after_bit_r2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(bit_en_i));

  p_start_no_done_r7: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !done_o);

  p_lsb_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_i == ($clog2(NWORDS))'(NWORDS - 1)) |=> (rd_data_o[0] == 1'b0));

  p_short_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (done_o && !long_q) |-> (rsp[1] == '0 && rsp[2] == '0 && rsp[3] == '0));

  p_words_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !(busy && bit_en_i)) |=> $stable(rsp));
endmodule

bind sd_rsp_deser sdrc_chk #(.WORD_W(P_WORD_W), .NWORDS(P_NWORDS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .bit_en_i (bit_en_i),
  .done_o   (done_o),
  .rd_addr_i(rd_addr_i),
  .rd_data_o(rd_data_o),
  .busy     (busy),
  .long_q   (long_q),
  .rsp      (rsp_w)
);

// File: tb/sim_sd_rsp_deser.sv
`timescale 1ns/1ps
module sim_sd_rsp_deser;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        long_i = 1'b0;
  logic        bit_en_i = 1'b0;
  logic        bit_i = 1'b0;
  logic        done_o;
  logic [1:0]  rd_addr_i = 2'd0;
  logic [31:0] rd_data_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sd_rsp_deser u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .long_i(long_i),
    .bit_en_i(bit_en_i), .bit_i(bit_i), .done_o(done_o),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  // {gap[1:0], long, status[127:0]}
  localparam logic [130:0] VEC [6] = '{
    {2'd0, 1'b0, 128'h0000_0000_0000_0000_0000_0000_DEAD_BEEF},
    {2'd1, 1'b0, 128'h0000_0000_0000_0000_0000_0000_8000_0001},
    {2'd0, 1'b1, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210},
    {2'd2, 1'b1, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF},
    {2'd1, 1'b1, 128'h8000_0000_0000_0000_0000_0000_0000_0003},
    {2'd0, 1'b0, 128'h0000_0000_0000_0000_0000_0000_0000_0000}
  };

  function automatic logic [31:0] exp_word(input logic lng, input logic [127:0] s, input int idx);
    if (lng) begin
      case (idx)
        0: return s[127:96];
        1: return s[95:64];
        2: return s[63:32];
        default: return {s[31:1], 1'b0};
      endcase
    end
    return (idx == 0) ? s[31:0] : 32'h0;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_word(input int idx, input logic [31:0] exp, input string req);
    rd_addr_i = 2'(idx);
    @(negedge clk);
    chk(rd_data_o == exp, req, rd_data_o, exp);
  endtask

  // Sends n bits, MSB of the field first; checks the done pulse timing.
  task automatic shift_bits(input logic lng, input logic [127:0] s, input int gap, input string req);
    int  n = lng ? 127 : 32;
    logic early = 1'b0;
    for (int i = 0; i < n; i++) begin
      bit_i    = lng ? s[127-i] : s[31-i];
      bit_en_i = 1'b1;
      @(negedge clk);
      bit_en_i = 1'b0;
      if (i == n - 1) begin
        chk(done_o == 1'b1, {req, " R6 done rises"}, 32'(done_o), 32'd1);
        @(negedge clk);
        chk(done_o == 1'b0, {req, " R6 done single"}, 32'(done_o), 32'd0);
      end else begin
        if (done_o) early = 1'b1;
        for (int k = 0; k < gap; k++) begin
          bit_i = ~bit_i;
          @(negedge clk);
          if (done_o) early = 1'b1;
        end
      end
    end
    chk(!early, {req, " R2 no early done"}, 32'(early), 32'd0);
  endtask

  task automatic start_cap(input logic lng);
    long_i  = lng;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [127:0] s;
    logic         lng;
    int           gap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(done_o == 1'b0, "R1 done low", 32'(done_o), 32'd0);
    for (int i = 0; i < 4; i++) read_word(i, 32'h0, "R1 word zero");

    // Vector table: R2 R3 R4 R5 R8
    for (int v = 0; v < 6; v++) begin
      s   = VEC[v][127:0];
      lng = VEC[v][128];
      gap = int'(VEC[v][130:129]);
      start_cap(lng);
      shift_bits(lng, s, gap, lng ? "R4 vec" : "R3 vec");
      for (int i = 0; i < 4; i++)
        read_word(i, exp_word(lng, s, i), lng ? "R4 R5 word" : "R3 word");
    end

    // R7 abort of a long capture by a new start
    start_cap(1'b1);
    for (int i = 0; i < 50; i++) begin
      bit_i = 1'b1; bit_en_i = 1'b1; @(negedge clk);
    end
    bit_en_i = 1'b0;
    start_cap(1'b0);
    shift_bits(1'b0, 128'h1234_5678, 0, "R7 abort");
    read_word(0, 32'h1234_5678, "R7 abort word0");
    read_word(1, 32'h0, "R7 abort word1");

    // R7 start colliding with the final enabled bit
    start_cap(1'b0);
    for (int i = 0; i < 31; i++) begin
      bit_i = 1'b1; bit_en_i = 1'b1; @(negedge clk);
    end
    bit_i = 1'b1; bit_en_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; bit_en_i = 1'b0;
    chk(done_o == 1'b0, "R7 collision no done", 32'(done_o), 32'd0);
    read_word(0, 32'h0, "R7 collision cleared");
    shift_bits(1'b0, 128'hCAFE_F00D, 0, "R7 recount");
    read_word(0, 32'hCAFE_F00D, "R7 recount word0");

    // R6 trailing bits after completion are ignored
    for (int i = 0; i < 10; i++) begin
      bit_i = 1'b1; bit_en_i = 1'b1; @(negedge clk);
      chk(done_o == 1'b0, "R6 trailing no done", 32'(done_o), 32'd0);
    end
    bit_en_i = 1'b0;
    read_word(0, 32'hCAFE_F00D, "R6 trailing word0");

    // R9 mode latched at start
    start_cap(1'b0);
    long_i = 1'b1;
    shift_bits(1'b0, 128'hA5A5_0F0F, 1, "R9 mode latch");
    read_word(0, 32'hA5A5_0F0F, "R9 word0");
    read_word(3, 32'h0, "R9 word3");
    long_i = 1'b0;

    // R8 read latency: new address visible after one cycle
    rd_addr_i = 2'd1;
    @(negedge clk);
    rd_addr_i = 2'd0;
    @(negedge clk);
    chk(rd_data_o == 32'hA5A5_0F0F, "R8 latency", rd_data_o, 32'hA5A5_0F0F);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule